// File: doc/BRIEF.md
# Octal Channel Mode Controller

This block holds the mode of eight low-side output channels and turns it into three per-channel control vectors: a gate enable for the power switch, an enable for the open-load diagnostic sink current, and a fault-clear strobe that goes to the external fault latches. Software writes one 16-bit command word, which a serial interface delivers outside this block together with a one-cycle load strobe. Each channel takes a 2-bit code from that word and selects one of four modes: standby, routed to a parallel input, on, or off with the diagnostic current running.

Four parallel inputs each serve a pair of channels, so that pulse-width modulation does not need the serial path. Two level inputs choose the operating mode of the whole controller. A global enable switches between running and a low-current state. A limp-home input overrides everything: it turns on only the lower four channels straight from the parallel inputs and ignores commands. Fault latches outside the block report into it, and a latched fault holds its channel off whatever the mode. A synchronous power-on-reset input returns the controller to its power-up defaults.

Top module: `octal_mode_ctrl`

## Requirements
- R1: Channel n (n = 1..8) takes its code from command word bits [2n-1:2n-2]. A word presented with `cmd_load_i` high in running mode is stored at the next clock edge and acts from the following cycle.
- R2: Code 00 (standby): the gate is off, the diagnostic current is off, and `fault_clr_o` of that channel stays high for as long as the code is held.
- R3: Code 01 (routed): the gate follows parallel input k, where channels 1 and 5 use input 1 (bit 0), 2 and 6 use input 2, 3 and 7 use input 3, and 4 and 8 use input 4 (bit 3).
- R4: Code 10 (on): the gate is on.
- R5: Code 11 (off): the gate is off. The diagnostic current is on only once a command word has been stored since the last reset or reinitialisation.
- R6: After `rst_n` low or `por_i` high, every code is 11 and the controller is in low-current mode. The diagnostic current stays off until the first command word is stored.
- R7: While limp-home has been high for a full cycle, channels 1-4 gate from inputs 1-4 and their diagnostic current is on while the input is low. Channels 5-8 are off with the diagnostic current on. Command loads and the enable input are ignored, and no fault-clear is issued.
- R8: Leaving limp-home resets the command word to all ones and disarms the diagnostic current. It also raises `fault_clr_o` on all channels for exactly one cycle. The controller then runs if enable is high, or goes to low-current mode if enable is low.
- R9: Enable low with limp-home low gives low-current mode: all gates and diagnostic currents are off, all fault-clears are high, and the command word is reset.
- R10: A rising edge on enable with limp-home low reinitialises the controller to the power-up defaults. A load in that same cycle is dropped.
- R11: A channel whose fault input is high has its gate off in every mode.
- R12: In routed mode the diagnostic current is on exactly while the routed parallel input is low.
- R13: Enable, limp-home and load changes take effect one clock after they are sampled. Parallel inputs and fault inputs act on the outputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Synchronous power-on reset, active high |
| enable_i | input | 1 | Global enable level |
| limp_i | input | 1 | Limp-home override level |
| cmd_load_i | input | 1 | One-cycle strobe: command word is valid |
| cmd_word_i | input | 16 | Command word, 2 bits per channel |
| par_in_i | input | 4 | Parallel control inputs 1..4 (bit 0 = input 1) |
| fault_i | input | 8 | Latched fault per channel (bit 0 = channel 1) |
| gate_en_o | output | 8 | Gate enable per channel |
| diag_en_o | output | 8 | Open-load diagnostic current enable per channel |
| fault_clr_o | output | 8 | Fault-clear strobe per channel |

## Verification
The mixed word 16'h39E4 puts all four codes side by side, and each code appears on a lower and an upper channel. Sweeping all sixteen parallel-input values under this word shows whether the field positions, the channel pairing and the routed-mode diagnostic polarity are right. Uniform words (0000, 5555, AAAA, FFFF) with fault patterns applied separate the per-code behaviour and the fault override from the routing. Limp entry and exit are tried with enable both high and low, and with loads and enable toggles during the override, which exposes the reset-on-exit and the one-cycle clear. A long random run with rare power-on resets and mode changes then catches ordering mistakes between reinitialisation, loads and edge detection.

// File: rtl/omc_pkg.sv
package omc_pkg;

  typedef enum logic [1:0] {
    OPM_LOWQ = 2'd0,
    OPM_RUN  = 2'd1,
    OPM_LIMP = 2'd2
  } opmode_e;

  typedef enum logic [1:0] {
    CC_STBY = 2'b00,
    CC_PAR  = 2'b01,
    CC_ON   = 2'b10,
    CC_OFF  = 2'b11
  } chcode_e;

  typedef struct packed {
    logic gate;
    logic diag;
    logic clr;
  } chan_drive_t;

endpackage

// File: rtl/omc_mode_fsm.sv
module omc_mode_fsm
  import omc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    por_i,
  input  logic    enable_i,
  input  logic    limp_i,
  output opmode_e mode_o,
  output logic    reinit_o,
  output logic    hold_o,
  output logic    exit_pulse_o
);

  opmode_e mode_q, mode_d;
  logic    en_q, en_d;
  logic    exit_q, exit_d;
  logic    leaving_limp;
  logic    en_rise;

  always_comb begin
    leaving_limp = (mode_q == OPM_LIMP) && !limp_i;
    en_rise      = enable_i && !en_q && !limp_i;

    if (limp_i)        mode_d = OPM_LIMP;
    else if (enable_i) mode_d = OPM_RUN;
    else               mode_d = OPM_LOWQ;
    en_d   = enable_i;
    exit_d = leaving_limp;

    if (por_i) begin
      mode_d = OPM_LOWQ;
      en_d   = 1'b0;
      exit_d = 1'b0;
    end

    reinit_o = !limp_i && (leaving_limp || !enable_i || en_rise);
    hold_o   = limp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= OPM_LOWQ;
      en_q   <= 1'b0;
      exit_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      en_q   <= en_d;
      exit_q <= exit_d;
    end
  end

  assign mode_o       = mode_q;
  assign exit_pulse_o = exit_q;

endmodule

// File: rtl/omc_cmd_reg.sv
module omc_cmd_reg #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_i,
  input  logic              reinit_i,
  input  logic              hold_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] cmd_o,
  output logic              armed_o
);

  logic [WORD_W-1:0] cmd_q, cmd_d;
  logic              arm_q, arm_d;
  logic              upd_en;

  always_comb begin
    upd_en = 1'b0;
    cmd_d  = cmd_q;
    arm_d  = arm_q;
    if (por_i || (!hold_i && reinit_i)) begin
      upd_en = 1'b1;
      cmd_d  = '1;
      arm_d  = 1'b0;
    end else if (!hold_i && load_i) begin
      upd_en = 1'b1;
      cmd_d  = word_i;
      arm_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '1;
      arm_q <= 1'b0;
    end else if (upd_en) begin
      cmd_q <= cmd_d;
      arm_q <= arm_d;
    end
  end

  assign cmd_o   = cmd_q;
  assign armed_o = arm_q;

endmodule

// File: rtl/omc_chan_ctrl.sv
module omc_chan_ctrl
  import omc_pkg::*;
#(
  parameter bit LIMP_MEMBER = 1'b1
) (
  input  opmode_e     mode_i,
  input  logic [1:0]  code_i,
  input  logic        armed_i,
  input  logic        par_i,
  input  logic        fault_i,
  input  logic        exit_pulse_i,
  output chan_drive_t drive_o
);

  chcode_e     cc;
  chan_drive_t raw;

  always_comb begin
    cc  = chcode_e'(code_i);
    raw = '0;
    unique case (mode_i)
      OPM_LOWQ: raw.clr = 1'b1;
      OPM_LIMP: begin
        if (LIMP_MEMBER) begin
          raw.gate = par_i;
          raw.diag = !par_i;
        end else begin
          raw.diag = 1'b1;
        end
      end
      OPM_RUN: begin
        unique case (cc)
          CC_STBY: raw.clr  = 1'b1;
          CC_PAR: begin
            raw.gate = par_i;
            raw.diag = !par_i;
          end
          CC_ON:   raw.gate = 1'b1;
          CC_OFF:  raw.diag = armed_i;
          default: raw      = '0;
        endcase
      end
      default: raw = '0;
    endcase

    drive_o.gate = raw.gate && !fault_i;
    drive_o.diag = raw.diag;
    drive_o.clr  = raw.clr || exit_pulse_i;
  end

endmodule

// File: rtl/octal_mode_ctrl.sv
module octal_mode_ctrl
  import omc_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int PAR_W   = 4,
  parameter int LIMP_CH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     por_i,
  input  logic                     enable_i,
  input  logic                     limp_i,
  input  logic                     cmd_load_i,
  input  logic [2*NUM_CH-1:0]      cmd_word_i,
  input  logic [PAR_W-1:0]         par_in_i,
  input  logic [NUM_CH-1:0]        fault_i,
  output logic [NUM_CH-1:0]        gate_en_o,
  output logic [NUM_CH-1:0]        diag_en_o,
  output logic [NUM_CH-1:0]        fault_clr_o
);

  localparam int CODE_W = 2;
  localparam int WORD_W = NUM_CH * CODE_W;

  opmode_e           mode;
  logic              reinit;
  logic              hold;
  logic              exit_pulse;
  logic [WORD_W-1:0] cmd;
  logic              armed;

  omc_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .por_i        (por_i),
    .enable_i     (enable_i),
    .limp_i       (limp_i),
    .mode_o       (mode),
    .reinit_o     (reinit),
    .hold_o       (hold),
    .exit_pulse_o (exit_pulse)
  );

  omc_cmd_reg #(.WORD_W(WORD_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_i    (por_i),
    .reinit_i (reinit),
    .hold_i   (hold),
    .load_i   (cmd_load_i),
    .word_i   (cmd_word_i),
    .cmd_o    (cmd),
    .armed_o  (armed)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    localparam int PIDX = g % PAR_W;
    localparam bit LM   = (g < LIMP_CH);
    chan_drive_t drv;

    omc_chan_ctrl #(.LIMP_MEMBER(LM)) u_ch (
      .mode_i       (mode),
      .code_i       (cmd[g*CODE_W +: CODE_W]),
      .armed_i      (armed),
      .par_i        (par_in_i[PIDX]),
      .fault_i      (fault_i[g]),
      .exit_pulse_i (exit_pulse),
      .drive_o      (drv)
    );

    assign gate_en_o[g]   = drv.gate;
    assign diag_en_o[g]   = drv.diag;
    assign fault_clr_o[g] = drv.clr;
  end

endmodule

// File: rtl/omc_checker.sv
module omc_checker #(
  parameter int NUM_CH  = 8,
  parameter int LIMP_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable_i,
  input logic              limp_i,
  input logic [NUM_CH-1:0] fault_i,
  input logic [NUM_CH-1:0] gate_en_o,
  input logic [NUM_CH-1:0] diag_en_o,
  input logic [NUM_CH-1:0] fault_clr_o
);

  assert_fault_holds_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en_o & fault_i) == '0);

  assert_gate_diag_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en_o & diag_en_o) == '0);

  assert_clear_only_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr_o & gate_en_o) == '0);

  assert_limp_upper_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (limp_i && $past(limp_i)) |-> (gate_en_o[NUM_CH-1:LIMP_CH] == '0));

  assert_lowq_all_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && !limp_i && $past(!enable_i && !limp_i))
      |-> (gate_en_o == '0 && diag_en_o == '0 && (&fault_clr_o)));

endmodule

bind octal_mode_ctrl omc_checker #(.NUM_CH(NUM_CH), .LIMP_CH(LIMP_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable_i    (enable_i),
  .limp_i      (limp_i),
  .fault_i     (fault_i),
  .gate_en_o   (gate_en_o),
  .diag_en_o   (diag_en_o),
  .fault_clr_o (fault_clr_o)
);

// File: tb/sim_octal_mode_ctrl.sv
`timescale 1ns/1ps
module sim_octal_mode_ctrl;

  logic        clk;
  logic        rst_n;
  logic        por;
  logic        enable;
  logic        limp;
  logic        load;
  logic [15:0] word;
  logic [3:0]  par;
  logic [7:0]  fault;
  logic [7:0]  gate_en, diag_en, fault_clr;

  int    checks = 0;
  int    errors = 0;
  bit    run_cmp = 0;
  bit    done = 0;
  string cur_req = "R6";

  // reference model state: mode 0 low-current, 1 running, 2 limp
  int        m_mode;
  logic [15:0] m_cmd;
  bit        m_arm, m_exit, m_en_q;

  octal_mode_ctrl u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_i       (por),
    .enable_i    (enable),
    .limp_i      (limp),
    .cmd_load_i  (load),
    .cmd_word_i  (word),
    .par_in_i    (par),
    .fault_i     (fault),
    .gate_en_o   (gate_en),
    .diag_en_o   (diag_en),
    .fault_clr_o (fault_clr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    int nm;
    bit ex, rise;
    if (!rst_n) begin
      m_mode = 0; m_cmd = 16'hFFFF; m_arm = 0; m_exit = 0; m_en_q = 0;
    end else begin
      nm   = limp ? 2 : (enable ? 1 : 0);
      ex   = (m_mode == 2) && !limp;
      rise = enable && !m_en_q && !limp;
      if (por) begin
        m_cmd = 16'hFFFF; m_arm = 0; m_mode = 0; m_en_q = 0; m_exit = 0;
      end else begin
        if (!limp) begin
          if (ex || !enable || rise) begin
            m_cmd = 16'hFFFF; m_arm = 0;
          end else if (load) begin
            m_cmd = word; m_arm = 1;
          end
        end
        m_exit = ex;
        m_mode = nm;
        m_en_q = enable;
      end
    end
  end

  task automatic compare();
    logic [7:0] eg, ed, ec;
    for (int i = 0; i < 8; i++) begin
      logic [1:0] code;
      logic p, f;
      code = m_cmd[2*i +: 2];
      p = par[i % 4];
      f = fault[i];
      eg[i] = 0; ed[i] = 0; ec[i] = 0;
      if (m_mode == 0) begin
        ec[i] = 1;
      end else if (m_mode == 2) begin
        if (i < 4) begin eg[i] = p; ed[i] = !p; end
        else ed[i] = 1;
      end else begin
        case (code)
          2'b00: ec[i] = 1;
          2'b01: begin eg[i] = p; ed[i] = !p; end
          2'b10: eg[i] = 1;
          default: ed[i] = m_arm;
        endcase
      end
      if (f) eg[i] = 0;
      if (m_exit) ec[i] = 1;
    end
    checks++;
    if (gate_en !== eg) begin
      errors++;
      $display("FAIL %s gate_en actual %h expected %h at %0t", cur_req, gate_en, eg, $time);
    end
    checks++;
    if (diag_en !== ed) begin
      errors++;
      $display("FAIL %s diag_en actual %h expected %h at %0t", cur_req, diag_en, ed, $time);
    end
    checks++;
    if (fault_clr !== ec) begin
      errors++;
      $display("FAIL %s fault_clr actual %h expected %h at %0t", cur_req, fault_clr, ec, $time);
    end
  endtask

  always @(negedge clk) begin
    #3;
    if (run_cmp && !done) compare();
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic put_word(input logic [15:0] w);
    word = w; load = 1'b1;
    tick();
    load = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R13 watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 0; por = 0; enable = 0; limp = 0; load = 0;
    word = 16'h0; par = 4'h0; fault = 8'h00;
    repeat (2) @(posedge clk);
    run_cmp = 1;
    cur_req = "R6";
    tick(); tick();
    rst_n = 1;
    tick();
    enable = 1;
    repeat (3) tick();

    // R1 / R3 / R12: mixed codes, sweep parallel inputs
    cur_req = "R1";
    put_word(16'h39E4);
    cur_req = "R3";
    for (int p = 0; p < 16; p++) begin par = 4'(p); tick(); end
    cur_req = "R12";
    for (int p = 15; p >= 0; p--) begin par = 4'(p); tick(); end
    // R11: faults across all modes
    cur_req = "R11";
    par = 4'hF;
    fault = 8'hFF; tick();
    fault = 8'hA5; tick();
    fault = 8'h5A; tick();
    fault = 8'h00; tick();

    cur_req = "R4";
    put_word(16'hAAAA); tick();
    fault = 8'h3C; tick(); fault = 8'h00; tick();

    cur_req = "R2";
    put_word(16'h0000); fault = 8'h0F; tick(); tick(); fault = 8'h00; tick();

    cur_req = "R5";
    put_word(16'hFFFF); tick(); tick();

    cur_req = "R3";
    put_word(16'h5555);
    for (int p = 0; p < 16; p++) begin par = 4'(p); tick(); end

    // R7: limp-home override
    cur_req = "R7";
    put_word(16'hAAAA);
    limp = 1; tick();
    word = 16'h0000; load = 1; tick(); load = 0;
    enable = 0; tick(); enable = 1; tick();
    for (int p = 0; p < 16; p++) begin par = 4'(p); tick(); end
    fault = 8'h11; tick(); fault = 8'h00; tick();

    // R8: exit with enable high then low
    cur_req = "R8";
    par = 4'hF;
    limp = 0; tick(); tick(); tick();
    put_word(16'h5555); tick();
    limp = 1; tick(); tick();
    enable = 0; tick();
    limp = 0; tick(); tick();

    // R9: low-current mode ignores loads
    cur_req = "R9";
    put_word(16'hAAAA); tick(); tick();

    // R10: enable rise with load in the same cycle
    cur_req = "R10";
    enable = 1; word = 16'hAAAA; load = 1; tick();
    load = 0; tick(); tick();
    put_word(16'hFFFF); tick();

    // R6: synchronous power-on reset
    cur_req = "R6";
    put_word(16'hAAAA); tick();
    por = 1; tick(); por = 0; tick(); tick(); tick();

    // R13: random mix
    cur_req = "R13";
    for (int n = 0; n < 4000; n++) begin
      por    = ($urandom % 97) == 0;
      limp   = (($urandom % 40) == 0) ? ~limp : limp;
      enable = (($urandom % 30) == 0) ? ~enable : enable;
      load   = ($urandom % 4) == 0;
      word   = 16'($urandom);
      par    = 4'($urandom);
      fault  = (($urandom % 5) == 0) ? 8'($urandom) : 8'h00;
      tick();
    end
    por = 0; load = 0;
    tick();
    finish_run();
  end

endmodule